// File: doc/BRIEF.md
# Two-Thread Partitioned Reorder Buffer

This block keeps program order for a core that runs two hardware threads out of order. Its storage is split into two fixed, equal partitions, one per thread. Each partition is its own circular queue with its own head and tail. The front end dispatches instructions one per cycle, and each one receives a global entry index. The index is the thread bit followed by the slot within that thread's partition. Execution units later report results against that index on a completion port. A separate port reports how branches resolved.

Each thread retires at most one entry per cycle, always from its partition head. The head entry retires only when it holds a finished result. A branch at the head also has to be resolved first, so every result behind a branch waits until that branch is settled. A mispredicted branch discards every younger entry of its thread and drives a redirect carrying the corrected fetch address. When the head entry finished with a fault, the block reports it instead of retiring it and empties that thread's partition.

Top module: `tp_rob_top`

## Requirements
- R1: After reset both partitions are empty. `dispStall`, `commitValid`, `excValid` and `redirectValid` are all 0.
- R2: Dispatch to thread t is accepted in the same cycle it is presented. `dispIdx` is {t, slot}: bit IDX_W-1 is the thread and the low bits are the slot. Successive dispatches of one thread get consecutive slots, modulo ENTRIES.
- R3: When thread t holds ENTRIES live entries, `dispStall[t]` is 1 and dispatch to t is refused (`dispAccept`=0). Dispatch to the other thread is still accepted, and the stall drops in the cycle after a head commit.
- R4: Per thread, at most one entry retires per cycle, in program order. `commitValid[t]` is 1 only while the head entry is complete. A younger entry that finished earlier does not retire ahead of an unfinished head.
- R5: A branch entry at the head does not retire until the resolve port reports it. A correct resolve lets the branch and the finished entries behind it retire on the following cycles.
- R6: A mispredict resolve on a live branch of thread t does three things. In the next cycle it raises `redirectValid` with `redirectThread`=t and `redirectPc` equal to the given target. It discards all younger entries of t, so the next dispatch to t gets the slot right after the branch. The branch itself still retires.
- R7: A head entry whose completion carried the exception flag raises `excValid[t]` without `commitValid[t]`. On the next cycle the partition of t is empty, and the next dispatch to t gets the faulting entry's slot.
- R8: Head and tail pointers carry one wrap bit beyond the slot bits, so a full partition and an empty one are told apart. After ENTRIES allocations and retirements the slot numbering wraps to where it began.
- R9: Completion and resolve reports that name an entry which is not live have no effect. In particular, they do not cause a retirement or a redirect.
- R10: In a cycle where thread t is squashed by a mispredict or flushed by an exception, a dispatch to t is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispThread | input | 1 | Thread of the dispatched instruction |
| dispTag | input | TAG_W | Destination tag of the instruction |
| dispIsBranch | input | 1 | Instruction is a predicted branch |
| dispAccept | output | 1 | Dispatch taken this cycle |
| dispIdx | output | IDX_W | Entry index given to the dispatched instruction |
| dispStall | output | 2 | Per-thread partition full |
| cmplValid | input | 1 | Completion report |
| cmplIdx | input | IDX_W | Entry that finished |
| cmplData | input | DATA_W | Result value |
| cmplExc | input | 1 | Entry finished with a fault |
| resValid | input | 1 | Branch resolve report |
| resIdx | input | IDX_W | Branch entry being resolved |
| resMispredict | input | 1 | Branch was mispredicted |
| resTarget | input | PC_W | Corrected fetch address |
| commitValid | output | 2 | Per-thread head entry retires this cycle |
| commitTag | output | 2*TAG_W | Retiring tag, thread t in bits [t*TAG_W +: TAG_W] |
| commitData | output | 2*DATA_W | Retiring result, thread t in bits [t*DATA_W +: DATA_W] |
| excValid | output | 2 | Per-thread faulting head entry |
| redirectValid | output | 1 | Fetch restart request |
| redirectThread | output | 1 | Thread to restart |
| redirectPc | output | PC_W | Restart address |

## Verification
Several properties are checked on every cycle by assertions:
- occupancy never exceeds the partition size;
- a full partition's tail holds still unless that thread is squashed;
- a retirement moves the head by exactly one;
- an exception leaves the partition empty;
- a live mispredict is always followed by a redirect.

Other behaviour is only visible through the directed scenarios:
- retirement order when results arrive out of order;
- branches holding back younger results;
- which slot is reused after a squash or a flush;
- reports against dead entries being ignored;
- the partition wrapping around after a full fill.

// File: rtl/tp_rob_pkg.sv
package tp_rob_pkg;
  localparam int THREADS = 2;

  typedef struct packed {
    logic alloc;    // write a new entry at the allocation index
    logic cmpl;     // record a completion for a live entry
    logic resolve;  // mark a live branch entry resolved
  } robStrobe_t;
endpackage

// File: rtl/tp_rob_dpath.sv
module tp_rob_dpath
  import tp_rob_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 32,
  localparam int SLOT_W = $clog2(ENTRIES),
  localparam int IDX_W  = SLOT_W + 1,
  localparam int TOTAL  = THREADS * ENTRIES
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  robStrobe_t                     strobe,
  input  logic [IDX_W-1:0]               allocIdx,
  input  logic [TAG_W-1:0]               dispTag,
  input  logic                           dispIsBranch,
  input  logic [IDX_W-1:0]               cmplIdx,
  input  logic [DATA_W-1:0]              cmplData,
  input  logic                           cmplExc,
  input  logic [IDX_W-1:0]               resIdx,
  input  logic [THREADS-1:0][IDX_W-1:0]  headIdx,
  output logic [THREADS-1:0]             headReady,
  output logic [THREADS-1:0]             headExc,
  output logic [THREADS*TAG_W-1:0]       commitTag,
  output logic [THREADS*DATA_W-1:0]      commitData
);
  logic [TOTAL-1:0]  doneQ, excQ, brQ, resolvedQ;
  logic [TAG_W-1:0]  tagMem  [TOTAL];
  logic [DATA_W-1:0] dataMem [TOTAL];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ     <= '0;
      excQ      <= '0;
      brQ       <= '0;
      resolvedQ <= '0;
    end else begin
      if (strobe.alloc) begin
        doneQ[allocIdx]     <= 1'b0;
        excQ[allocIdx]      <= 1'b0;
        brQ[allocIdx]       <= dispIsBranch;
        resolvedQ[allocIdx] <= 1'b0;
      end
      if (strobe.cmpl) begin
        doneQ[cmplIdx] <= 1'b1;
        excQ[cmplIdx]  <= cmplExc;
      end
      if (strobe.resolve) begin
        doneQ[resIdx]     <= 1'b1;
        resolvedQ[resIdx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.alloc) tagMem[allocIdx] <= dispTag;
    if (strobe.cmpl)  dataMem[cmplIdx] <= cmplData;
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_head
    assign headReady[t] = doneQ[headIdx[t]] &&
                          (!brQ[headIdx[t]] || resolvedQ[headIdx[t]]);
    assign headExc[t]   = excQ[headIdx[t]];
    assign commitTag[t*TAG_W +: TAG_W]    = tagMem[headIdx[t]];
    assign commitData[t*DATA_W +: DATA_W] = dataMem[headIdx[t]];
  end

  AST_ALLOC_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> !doneQ[$past(allocIdx)]); // R2
endmodule

// File: rtl/tp_rob_ctrl.sv
module tp_rob_ctrl
  import tp_rob_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  localparam int SLOT_W = $clog2(ENTRIES),
  localparam int PTR_W  = SLOT_W + 1,
  localparam int IDX_W  = SLOT_W + 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           dispValid,
  input  logic                           dispThread,
  input  logic                           cmplValid,
  input  logic [IDX_W-1:0]               cmplIdx,
  input  logic                           resValid,
  input  logic [IDX_W-1:0]               resIdx,
  input  logic                           resMispredict,
  input  logic [PC_W-1:0]                resTarget,
  input  logic [THREADS-1:0]             headReady,
  input  logic [THREADS-1:0]             headExc,
  output robStrobe_t                     strobe,
  output logic [IDX_W-1:0]               allocIdx,
  output logic [THREADS-1:0][IDX_W-1:0]  headIdx,
  output logic                           dispAccept,
  output logic [THREADS-1:0]             dispStall,
  output logic [THREADS-1:0]             commitValid,
  output logic [THREADS-1:0]             excValid,
  output logic                           redirectValid,
  output logic                           redirectThread,
  output logic [PC_W-1:0]                redirectPc
);
  logic [THREADS-1:0][PTR_W-1:0] headPtr, tailPtr, cnt, squashTail;
  logic [THREADS-1:0][SLOT_W-1:0] cmplOff, resOff;
  logic [THREADS-1:0] isFull, isEmpty, cmplLive, resLive, misp;
  logic [THREADS-1:0] fireCommit, fireExc, allocT;

  for (genvar t = 0; t < THREADS; t++) begin : g_part
    assign cnt[t]        = tailPtr[t] - headPtr[t];
    assign isFull[t]     = cnt[t][SLOT_W];
    assign isEmpty[t]    = (cnt[t] == '0);
    assign headIdx[t]    = {1'(t), headPtr[t][SLOT_W-1:0]};
    assign cmplOff[t]    = cmplIdx[SLOT_W-1:0] - headPtr[t][SLOT_W-1:0];
    assign resOff[t]     = resIdx[SLOT_W-1:0] - headPtr[t][SLOT_W-1:0];
    assign cmplLive[t]   = (cmplIdx[IDX_W-1] == 1'(t)) && ({1'b0, cmplOff[t]} < cnt[t]);
    assign resLive[t]    = (resIdx[IDX_W-1] == 1'(t)) && ({1'b0, resOff[t]} < cnt[t]);
    assign misp[t]       = resValid && resMispredict && resLive[t];
    assign squashTail[t] = headPtr[t] + {1'b0, resOff[t]} + PTR_W'(1);
    assign fireCommit[t] = !isEmpty[t] && headReady[t] && !headExc[t];
    assign fireExc[t]    = !isEmpty[t] && headReady[t] && headExc[t];
    assign allocT[t]     = dispValid && (dispThread == 1'(t)) && !isFull[t] &&
                           !misp[t] && !fireExc[t];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        headPtr[t] <= '0;
        tailPtr[t] <= '0;
      end else if (fireExc[t]) begin
        tailPtr[t] <= headPtr[t];
      end else begin
        if (fireCommit[t]) headPtr[t] <= headPtr[t] + PTR_W'(1);
        if (misp[t])        tailPtr[t] <= squashTail[t];
        else if (allocT[t]) tailPtr[t] <= tailPtr[t] + PTR_W'(1);
      end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      cnt[t] <= PTR_W'(ENTRIES)); // R8
    AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rstN)
      (isFull[t] && !misp[t] && !fireExc[t]) |=> tailPtr[t] == $past(tailPtr[t])); // R3
    AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
      fireCommit[t] |=> headPtr[t] == $past(headPtr[t]) + PTR_W'(1)); // R4
    AST_EXC_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
      fireExc[t] |=> isEmpty[t]); // R7
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectValid  <= 1'b0;
      redirectThread <= 1'b0;
      redirectPc     <= '0;
    end else begin
      redirectValid <= |misp;
      if (|misp) begin
        redirectThread <= resIdx[IDX_W-1];
        redirectPc     <= resTarget;
      end
    end
  end

  assign allocIdx       = {dispThread, tailPtr[dispThread][SLOT_W-1:0]};
  assign strobe.alloc   = |allocT;
  assign strobe.cmpl    = cmplValid && |cmplLive;
  assign strobe.resolve = resValid && |resLive;
  assign dispAccept     = |allocT;
  assign dispStall      = isFull;
  assign commitValid    = fireCommit;
  assign excValid       = fireExc;

  AST_MISP_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resMispredict && |resLive) |=> redirectValid); // R6
endmodule

// File: rtl/tp_rob_top.sv
module tp_rob_top
  import tp_rob_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 32,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES) + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      dispValid,
  input  logic                      dispThread,
  input  logic [TAG_W-1:0]          dispTag,
  input  logic                      dispIsBranch,
  output logic                      dispAccept,
  output logic [IDX_W-1:0]          dispIdx,
  output logic [1:0]                dispStall,
  input  logic                      cmplValid,
  input  logic [IDX_W-1:0]          cmplIdx,
  input  logic [DATA_W-1:0]         cmplData,
  input  logic                      cmplExc,
  input  logic                      resValid,
  input  logic [IDX_W-1:0]          resIdx,
  input  logic                      resMispredict,
  input  logic [PC_W-1:0]           resTarget,
  output logic [1:0]                commitValid,
  output logic [2*TAG_W-1:0]        commitTag,
  output logic [2*DATA_W-1:0]       commitData,
  output logic [1:0]                excValid,
  output logic                      redirectValid,
  output logic                      redirectThread,
  output logic [PC_W-1:0]           redirectPc
);
  robStrobe_t                     strobe;
  logic [IDX_W-1:0]               allocIdx;
  logic [THREADS-1:0][IDX_W-1:0]  headIdx;
  logic [THREADS-1:0]             headReady, headExc;

  tp_rob_ctrl #(.ENTRIES(ENTRIES), .PC_W(PC_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispThread(dispThread),
    .cmplValid(cmplValid), .cmplIdx(cmplIdx),
    .resValid(resValid), .resIdx(resIdx), .resMispredict(resMispredict),
    .resTarget(resTarget),
    .headReady(headReady), .headExc(headExc),
    .strobe(strobe), .allocIdx(allocIdx), .headIdx(headIdx),
    .dispAccept(dispAccept), .dispStall(dispStall),
    .commitValid(commitValid), .excValid(excValid),
    .redirectValid(redirectValid), .redirectThread(redirectThread),
    .redirectPc(redirectPc)
  );

  tp_rob_dpath #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocIdx(allocIdx),
    .dispTag(dispTag), .dispIsBranch(dispIsBranch),
    .cmplIdx(cmplIdx), .cmplData(cmplData), .cmplExc(cmplExc),
    .resIdx(resIdx), .headIdx(headIdx),
    .headReady(headReady), .headExc(headExc),
    .commitTag(commitTag), .commitData(commitData)
  );

  assign dispIdx = allocIdx;
endmodule

// File: tb/tp_rob_top_tb.sv
module tp_rob_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 64;
  localparam int TAG_W = 6;
  localparam int DATA_W = 32;
  localparam int PC_W = 32;
  localparam int IDX_W = $clog2(ENTRIES) + 1;

  logic clk = 1'b0;
  logic rstN;
  logic dispValid, dispThread, dispIsBranch;
  logic [TAG_W-1:0] dispTag;
  logic dispAccept;
  logic [IDX_W-1:0] dispIdx;
  logic [1:0] dispStall;
  logic cmplValid, cmplExc;
  logic [IDX_W-1:0] cmplIdx;
  logic [DATA_W-1:0] cmplData;
  logic resValid, resMispredict;
  logic [IDX_W-1:0] resIdx;
  logic [PC_W-1:0] resTarget;
  logic [1:0] commitValid, excValid;
  logic [2*TAG_W-1:0] commitTag;
  logic [2*DATA_W-1:0] commitData;
  logic redirectValid, redirectThread;
  logic [PC_W-1:0] redirectPc;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tp_rob_top #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W), .PC_W(PC_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispThread(dispThread), .dispTag(dispTag),
    .dispIsBranch(dispIsBranch), .dispAccept(dispAccept), .dispIdx(dispIdx),
    .dispStall(dispStall),
    .cmplValid(cmplValid), .cmplIdx(cmplIdx), .cmplData(cmplData), .cmplExc(cmplExc),
    .resValid(resValid), .resIdx(resIdx), .resMispredict(resMispredict),
    .resTarget(resTarget),
    .commitValid(commitValid), .commitTag(commitTag), .commitData(commitData),
    .excValid(excValid), .redirectValid(redirectValid),
    .redirectThread(redirectThread), .redirectPc(redirectPc)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    dispValid = 0; dispThread = 0; dispTag = '0; dispIsBranch = 0;
    cmplValid = 0; cmplIdx = '0; cmplData = '0; cmplExc = 0;
    resValid = 0; resIdx = '0; resMispredict = 0; resTarget = '0;
  endtask

  // Called one time unit after a rising edge; returns at the same phase.
  task automatic step();
    @(posedge clk); #1;
    idleInputs();
  endtask

  task automatic dispatch(input bit t, input int tag, input bit br,
                          input bit expAcc, input int expIdx, input string req);
    dispValid = 1; dispThread = t; dispTag = TAG_W'(tag); dispIsBranch = br;
    #1;
    chk(req, "dispAccept", 64'(dispAccept), 64'(expAcc));
    if (expAcc) chk(req, "dispIdx", 64'(dispIdx), 64'(expIdx));
    step();
  endtask

  task automatic complete(input int idx, input int data, input bit exc);
    cmplValid = 1; cmplIdx = IDX_W'(idx); cmplData = DATA_W'(data); cmplExc = exc;
    step();
  endtask

  task automatic expectCommit(input bit t, input bit v, input int tag, input string req);
    chk(req, "commitValid", 64'(commitValid[t]), 64'(v));
    if (v) chk(req, "commitTag", 64'(commitTag[t*TAG_W +: TAG_W]), 64'(tag));
  endtask

  task automatic testReset();
    chk("R1", "dispStall", 64'(dispStall), 64'd0);
    chk("R1", "commitValid", 64'(commitValid), 64'd0);
    chk("R1", "excValid", 64'(excValid), 64'd0);
    chk("R1", "redirectValid", 64'(redirectValid), 64'd0);
  endtask

  task automatic testOrder();
    dispatch(0, 1, 0, 1, 0, "R2");
    dispatch(0, 2, 0, 1, 1, "R2");
    dispatch(0, 3, 0, 1, 2, "R2");
    complete(2, 32'h30, 0);
    expectCommit(0, 0, 0, "R4");
    complete(1, 32'h20, 0);
    expectCommit(0, 0, 0, "R4");
    complete(0, 32'h10, 0);
    expectCommit(0, 1, 1, "R4");
    chk("R4", "commitData", 64'(commitData[DATA_W-1:0]), 64'h10);
    step();
    expectCommit(0, 1, 2, "R4");
    step();
    expectCommit(0, 1, 3, "R4");
    chk("R4", "commitData", 64'(commitData[DATA_W-1:0]), 64'h30);
    step();
    expectCommit(0, 0, 0, "R4");
  endtask

  task automatic testException();
    dispatch(0, 7, 0, 1, 3, "R7");
    dispatch(0, 8, 0, 1, 4, "R7");
    complete(3, 32'hbad, 1);
    chk("R7", "excValid", 64'(excValid[0]), 64'd1);
    chk("R7", "commitValid", 64'(commitValid[0]), 64'd0);
    step();
    chk("R7", "excValid after flush", 64'(excValid[0]), 64'd0);
    complete(4, 32'h44, 0);   // entry was flushed, report ignored
    expectCommit(0, 0, 0, "R9");
    dispatch(0, 9, 0, 1, 3, "R7");
    complete(3, 32'h99, 0);
    expectCommit(0, 1, 9, "R7");
    step();
  endtask

  task automatic testBranch();
    dispatch(1, 11, 1, 1, 64, "R2");
    dispatch(1, 12, 0, 1, 65, "R2");
    dispatch(1, 13, 0, 1, 66, "R2");
    complete(65, 32'hc, 0);
    complete(66, 32'hd, 0);
    expectCommit(1, 0, 0, "R5");
    step();
    expectCommit(1, 0, 0, "R5");
    resValid = 1; resIdx = 64; resMispredict = 0;
    step();
    expectCommit(1, 1, 11, "R5");
    chk("R5", "redirectValid", 64'(redirectValid), 64'd0);
    step();
    expectCommit(1, 1, 12, "R5");
    step();
    expectCommit(1, 1, 13, "R5");
    step();
    expectCommit(1, 0, 0, "R5");
  endtask

  task automatic testMispredict();
    dispatch(1, 21, 1, 1, 67, "R6");
    dispatch(1, 22, 0, 1, 68, "R6");
    dispatch(1, 23, 0, 1, 69, "R6");
    complete(68, 32'h22, 0);
    resValid = 1; resIdx = 67; resMispredict = 1; resTarget = 32'h1234;
    dispValid = 1; dispThread = 1; dispTag = 6'd30;
    #1;
    chk("R10", "dispAccept during squash", 64'(dispAccept), 64'd0);
    step();
    chk("R6", "redirectValid", 64'(redirectValid), 64'd1);
    chk("R6", "redirectThread", 64'(redirectThread), 64'd1);
    chk("R6", "redirectPc", 64'(redirectPc), 64'h1234);
    expectCommit(1, 1, 21, "R6");
    step();
    expectCommit(1, 0, 0, "R6");
    resValid = 1; resIdx = 69; resMispredict = 1; resTarget = 32'h5555;
    step();
    chk("R9", "redirect on dead entry", 64'(redirectValid), 64'd0);
    dispatch(1, 24, 0, 1, 68, "R6");
    complete(68, 32'h24, 0);
    expectCommit(1, 1, 24, "R6");
    step();
  endtask

  task automatic testFull();
    for (int i = 0; i < ENTRIES; i++) dispatch(0, i, 0, 1, (4 + i) % ENTRIES, "R3");
    chk("R3", "dispStall full", 64'(dispStall), 64'b01);
    dispatch(0, 5, 0, 0, 0, "R3");
    dispatch(1, 40, 0, 1, 69, "R3");
    complete(4, 32'h400, 0);
    expectCommit(0, 1, 0, "R8");
    chk("R3", "dispStall before retire", 64'(dispStall[0]), 64'd1);
    step();
    chk("R3", "dispStall after retire", 64'(dispStall[0]), 64'd0);
    for (int i = 1; i < ENTRIES; i++) complete((4 + i) % ENTRIES, i, 0);
    complete(69, 32'h40, 0);
    for (int i = 0; i < 3; i++) step();
    chk("R8", "drained commitValid", 64'(commitValid), 64'd0);
    chk("R8", "drained dispStall", 64'(dispStall), 64'd0);
    dispatch(0, 50, 0, 1, 4, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    idleInputs();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1;
    testReset();
    testOrder();
    testException();
    testBranch();
    testMispredict();
    testFull();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule